// File: doc/BRIEF.md
# PWM Fault Disable Mapper

This block sits between the PWM generators and the output pins and overrides selected pins when an external fault is present. Each fault input has its own polarity select. A mapping matrix states which faults disable which pins. A pin that is disabled is driven to its own safe value: low, high or high impedance. The generators keep running underneath, so a pin that is released shows the live PWM value right away.

Each fault raises a sticky flag. Software clears the flag with a write-one-to-clear strobe, and the strobe works only once the fault has gone away. Detection and latching run whether or not the module is enabled. The interrupt depends on the module enable, so a flag that latched while the module was disabled raises the interrupt as soon as the module is enabled, unless software cleared it first.

Top module: `pwm_fault_guard`

## Requirements
- R1: A fault is active when `fault_in[f] ^ fault_pol[f]` is 1, so with polarity 0 a high input is a fault. An active fault sets `fault_flag[f]` at the next clock edge.
- R2: A fault flag stays set after its input becomes inactive, for as long as no clear is accepted.
- R3: A `flag_clr[f]` strobe clears `fault_flag[f]` at the next edge only if fault f is inactive at that edge. A strobe while the fault is active leaves the flag set.
- R4: Bit `map_bank[o*NUM_FAULTS+f]` = 1 maps fault f onto pin o. Pin o is overridden while any mapped fault has its flag set or is active right now. The override takes effect combinationally, in the same cycle the fault appears.
- R5: An overridden pin follows `safe_sel[2*o+1:2*o]`: 00 drives `pwm_out`=0 with `pwm_oe`=1, 01 drives `pwm_out`=1 with `pwm_oe`=1, and 10 or 11 gives `pwm_oe`=0 with `pwm_out`=0.
- R6: A pin that is not overridden shows `pwm_raw[o]` with `pwm_oe`=1 in the same cycle. Once its override ends, it shows the current raw value.
- R7: Latching, clearing and overrides work the same whether `mod_en` is 0 or 1.
- R8: `irq` is 1 exactly when `mod_en` is 1 and some fault has both its flag and its `irq_en` bit set. This includes a flag that latched while `mod_en` was 0.
- R9: While `rst_n` is low, all fault flags are 0 and `irq` is 0, even when a fault is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | NUM_FAULTS | Fault pins |
| fault_pol | input | NUM_FAULTS | 1 makes a fault pin active low |
| map_bank | input | NUM_FAULTS*NUM_OUTS | One bank of NUM_FAULTS bits per pin: the faults that disable it |
| safe_sel | input | 2*NUM_OUTS | Safe state of each pin while overridden |
| pwm_raw | input | NUM_OUTS | Generator outputs |
| mod_en | input | 1 | Module enable (gates the interrupt) |
| flag_clr | input | NUM_FAULTS | Write-one-to-clear strobes for the flags |
| irq_en | input | NUM_FAULTS | Interrupt enable for each fault |
| pwm_out | output | NUM_OUTS | Pin values |
| pwm_oe | output | NUM_OUTS | Pin drive enables, 0 = high impedance |
| fault_flag | output | NUM_FAULTS | Latched fault flags |
| irq | output | 1 | Fault interrupt |

## Verification
The pin values and drive enables are combinational, so they are due in the same cycle an input changes. The flags and the interrupt are due one clock edge after a fault appears or a clear is strobed. The bench changes inputs on the falling edge and checks every output 1 ns later. At that point the flags show the state up to the previous rising edge. A bench model of the flags is then advanced at the rising edge using the inputs that were applied, so each check compares against the value that is due in that cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
   // Safe state of a pin while a fault overrides it
   typedef enum logic [1:0] {
      SAFE_LOW   = 2'b00,
      SAFE_HIGH  = 2'b01,
      SAFE_HIZ   = 2'b10,
      SAFE_HIZ_B = 2'b11
   } safe_e;
endpackage

// File: rtl/pfg_fault_cell.sv
// One fault channel: polarity, sticky flag, guarded clear
module pfg_fault_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_pin,
   input  logic invert,
   input  logic clr,
   output logic active,
   output logic flag
);
   assign active = fault_pin ^ invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (active) flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
   end
endmodule

// File: rtl/pfg_pin_gate.sv
// One output pin: pass-through or safe-state override
module pfg_pin_gate
   import pfg_pkg::*;
(
   input  logic       raw,
   input  logic [1:0] sel,
   input  logic       hit,
   output logic       pin,
   output logic       oe
);
   safe_e state;
   assign state = safe_e'(sel);

   always_comb begin
      pin = raw;
      oe  = 1'b1;
      if (hit) begin
         unique case (state)
            SAFE_LOW:  begin pin = 1'b0; oe = 1'b1; end
            SAFE_HIGH: begin pin = 1'b1; oe = 1'b1; end
            default:   begin pin = 1'b0; oe = 1'b0; end
         endcase
      end
   end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
   parameter int NUM_FAULTS = 4,
   parameter int NUM_OUTS   = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_FAULTS-1:0]          fault_in,
   input  logic [NUM_FAULTS-1:0]          fault_pol,
   input  logic [NUM_FAULTS*NUM_OUTS-1:0] map_bank,
   input  logic [2*NUM_OUTS-1:0]          safe_sel,
   input  logic [NUM_OUTS-1:0]            pwm_raw,
   input  logic                           mod_en,
   input  logic [NUM_FAULTS-1:0]          flag_clr,
   input  logic [NUM_FAULTS-1:0]          irq_en,
   output logic [NUM_OUTS-1:0]            pwm_out,
   output logic [NUM_OUTS-1:0]            pwm_oe,
   output logic [NUM_FAULTS-1:0]          fault_flag,
   output logic                           irq
);
   localparam int BANK_W = NUM_FAULTS;
   localparam int SEL_W  = 2;

   generate
      if (NUM_FAULTS < 1 || NUM_FAULTS > 16) begin : g_bad_faults
         $error("NUM_FAULTS must be 1..16");
      end
      if (NUM_OUTS < 1 || NUM_OUTS > 32) begin : g_bad_outs
         $error("NUM_OUTS must be 1..32");
      end
   endgenerate

   logic [NUM_FAULTS-1:0] act;
   logic [NUM_FAULTS-1:0] flg;
   logic [NUM_FAULTS-1:0] live;

   genvar f, o;
   generate
      for (f = 0; f < NUM_FAULTS; f++) begin : g_fault
         pfg_fault_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .fault_pin (fault_in[f]),
            .invert    (fault_pol[f]),
            .clr       (flag_clr[f]),
            .active    (act[f]),
            .flag      (flg[f])
         );
      end
   endgenerate

   // Override sources: latched flags plus faults present this cycle
   assign live = flg | act;

   generate
      for (o = 0; o < NUM_OUTS; o++) begin : g_pin
         logic hit;
         assign hit = |(map_bank[o*BANK_W +: BANK_W] & live);
         pfg_pin_gate u_gate (
            .raw (pwm_raw[o]),
            .sel (safe_sel[o*SEL_W +: SEL_W]),
            .hit (hit),
            .pin (pwm_out[o]),
            .oe  (pwm_oe[o])
         );
      end
   endgenerate

   assign fault_flag = flg;
   assign irq        = mod_en & |(flg & irq_en);
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
   parameter int NUM_FAULTS = 4,
   parameter int NUM_OUTS   = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_FAULTS-1:0] fault_in,
   input logic [NUM_FAULTS-1:0] fault_pol,
   input logic                  mod_en,
   input logic [NUM_FAULTS-1:0] flag_clr,
   input logic [NUM_FAULTS-1:0] irq_en,
   input logic [NUM_OUTS-1:0]   pwm_out,
   input logic [NUM_OUTS-1:0]   pwm_oe,
   input logic [NUM_FAULTS-1:0] fault_flag,
   input logic                  irq
);
   assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(fault_in ^ fault_pol) & ~fault_flag) == '0));

   assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(fault_flag & ~flag_clr) & ~fault_flag) == '0));

   assert_clear_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((fault_flag & $past(flag_clr & ~(fault_in ^ fault_pol))) == '0));

   assert_hiz_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwm_out & ~pwm_oe) == '0));

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |-> !irq);

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((fault_flag & irq_en) != '0));
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(
   .NUM_FAULTS (NUM_FAULTS),
   .NUM_OUTS   (NUM_OUTS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fault_in   (fault_in),
   .fault_pol  (fault_pol),
   .mod_en     (mod_en),
   .flag_clr   (flag_clr),
   .irq_en     (irq_en),
   .pwm_out    (pwm_out),
   .pwm_oe     (pwm_oe),
   .fault_flag (fault_flag),
   .irq        (irq)
);

// File: tb/pwm_fault_guard_bench.sv
module pwm_fault_guard_bench;
   localparam int NF = 4;
   localparam int NO = 6;
   // pin0<-f0, pin1<-f1, pin2<-f0|f2, pin3<-f3, pin4 none, pin5<-f1|f3
   localparam logic [NF*NO-1:0] MAP = 24'hA08521;
   // pin0 low, pin1 high, pin2 hiz, pin3 high, pin4 low, pin5 hiz(11)
   localparam logic [2*NO-1:0]  SEL = 12'hC64;

   // {mod_en, irq_en[3:0], clr[3:0], pol[3:0], fault[3:0], raw[5:0]}
   localparam int NV = 12;
   localparam logic [22:0] VEC [0:NV-1] = '{
      {1'b1, 4'hF, 4'h0, 4'h0, 4'h0, 6'b101010},
      {1'b1, 4'hF, 4'h0, 4'h0, 4'h1, 6'b010101},
      {1'b1, 4'hF, 4'h0, 4'h0, 4'h0, 6'b111111},
      {1'b1, 4'hF, 4'h1, 4'h0, 4'h0, 6'b000000},
      {1'b1, 4'h0, 4'h0, 4'h0, 4'h2, 6'b110011},
      {1'b1, 4'h0, 4'h2, 4'h0, 4'h0, 6'b001100},
      {1'b1, 4'hF, 4'h0, 4'h8, 4'h8, 6'b100001},
      {1'b1, 4'hF, 4'h0, 4'h8, 4'h0, 6'b011110},
      {1'b1, 4'hF, 4'h8, 4'h0, 4'h0, 6'b111000},
      {1'b1, 4'h4, 4'h0, 4'h0, 4'h4, 6'b000111},
      {1'b1, 4'h4, 4'h4, 4'h0, 4'h0, 6'b101101},
      {1'b1, 4'hF, 4'h0, 4'h0, 4'h0, 6'b010010}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] fault_in = '0, fault_pol = '0, flag_clr = '0, irq_en = '0;
   logic [NO-1:0] pwm_raw = '0;
   logic          mod_en = 1'b0;
   logic [NO-1:0] pwm_out, pwm_oe;
   logic [NF-1:0] fault_flag;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   logic [NF-1:0] mflag = '0;
   bit done = 0;

   always #4 clk = ~clk;

   pwm_fault_guard #(.NUM_FAULTS(NF), .NUM_OUTS(NO)) u_pwm_fault_guard (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .fault_pol(fault_pol),
      .map_bank(MAP), .safe_sel(SEL), .pwm_raw(pwm_raw), .mod_en(mod_en),
      .flag_clr(flag_clr), .irq_en(irq_en), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
      .fault_flag(fault_flag), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected pins from R4/R5/R6
   task automatic ref_pins(input logic [NF-1:0] live, input logic [NO-1:0] raw,
                           output logic [NO-1:0] eo, output logic [NO-1:0] ee);
      for (int o = 0; o < NO; o++) begin
         logic [1:0] s;
         s = SEL[2*o +: 2];
         if ((MAP[o*NF +: NF] & live) != '0) begin
            ee[o] = (s[1] == 1'b0);
            eo[o] = (s == 2'b01);
         end else begin
            ee[o] = 1'b1;
            eo[o] = raw[o];
         end
      end
   endtask

   // Apply on falling edge, check 1 ns later, advance model at rising edge
   task automatic step(input logic [NF-1:0] fi, input logic [NF-1:0] pol,
                       input logic [NO-1:0] raw, input logic [NF-1:0] clr,
                       input logic [NF-1:0] ien, input logic en, input string tag);
      logic [NF-1:0] a;
      logic [NO-1:0] eo, ee;
      @(negedge clk);
      fault_in = fi; fault_pol = pol; pwm_raw = raw; flag_clr = clr;
      irq_en = ien; mod_en = en;
      #1;
      a = fi ^ pol;
      ref_pins(mflag | a, raw, eo, ee);
      chk(pwm_out == eo, {tag, " R4/R5/R6 pwm_out"}, 32'(pwm_out), 32'(eo));
      chk(pwm_oe == ee, {tag, " R5 pwm_oe"}, 32'(pwm_oe), 32'(ee));
      chk(fault_flag == mflag, {tag, " R2/R3 flag"}, 32'(fault_flag), 32'(mflag));
      chk(irq == (en & |(mflag & ien)), {tag, " R8 irq"}, 32'(irq), 32'(en & |(mflag & ien)));
      @(posedge clk);
      mflag = a | (mflag & ~clr);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R9: flags held clear in reset even with an active fault
      fault_in = 4'hF; irq_en = 4'hF; mod_en = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(fault_flag == '0, "R9 flags in reset", 32'(fault_flag), 0);
      chk(irq == 1'b0, "R9 irq in reset", 32'(irq), 0);
      @(negedge clk);
      fault_in = '0;
      rst_n = 1'b1;
      #1;
      chk(pwm_out == pwm_raw && pwm_oe == '1, "R6 idle pass-through", 32'(pwm_out), 32'(pwm_raw));

      // Table walk: R1 polarity, R2 sticky, R3 clear, R4 mapping, R5/R6 pins, R8 irq
      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         v = VEC[i];
         step(v[9:6], v[13:10], v[5:0], v[17:14], v[21:18], v[22], "table");
      end

      // R7: latching and override with module disabled, then R8 irq on enable
      step(4'h4, 4'h0, 6'b111111, 4'h0, 4'hF, 1'b0, "R7 latch while off");
      step(4'h0, 4'h0, 6'b111111, 4'h0, 4'hF, 1'b0, "R7 held while off");
      step(4'h0, 4'h0, 6'b000000, 4'h0, 4'hF, 1'b1, "R8 irq at enable");
      chk(irq == 1'b1, "R8 late irq", 32'(irq), 1);
      step(4'h0, 4'h0, 6'b000000, 4'h4, 4'hF, 1'b1, "R3 clear");
      step(4'h0, 4'h0, 6'b010101, 4'h0, 4'hF, 1'b1, "R3 cleared");
      chk(fault_flag == '0, "R3 flag gone", 32'(fault_flag), 0);

      // R3: clear while still active is ignored
      step(4'h1, 4'h0, 6'b000001, 4'h1, 4'h0, 1'b1, "R3 clr active");
      step(4'h1, 4'h0, 6'b000001, 4'h1, 4'h0, 1'b1, "R3 clr active2");
      chk(fault_flag[0] == 1'b1, "R3 flag kept", 32'(fault_flag), 1);

      // R6: generator toggles underneath an overridden pin; released pin shows live value
      step(4'h0, 4'h0, 6'b000001, 4'h0, 4'h0, 1'b1, "R6 held low");
      chk(pwm_out[0] == 1'b0, "R6 overridden pin0", 32'(pwm_out), 0);
      step(4'h0, 4'h0, 6'b000000, 4'h1, 4'h0, 1'b1, "R6 clear");
      step(4'h0, 4'h0, 6'b000001, 4'h0, 4'h0, 1'b1, "R6 released");
      chk(pwm_out[0] == 1'b1, "R6 live value", 32'(pwm_out), 1);

      // R1: inverted polarity, low input is a fault on f3 (pins 3 and 5)
      step(4'h0, 4'h8, 6'b000000, 4'h0, 4'h8, 1'b1, "R1 active low");
      step(4'h8, 4'h8, 6'b000000, 4'h0, 4'h8, 1'b1, "R1 idle high");
      chk(fault_flag[3] == 1'b1, "R1 inverted latch", 32'(fault_flag), 8);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule